// File: doc/BRIEF.md
# Bidirectional Pad Boundary Scan Cell Group

This block places a row of boundary scan cells between the core logic and a set of tri-state capable bidirectional pads. Each pad gets three independent scan elements. One observes and controls the pad input, one the output data and one the output enable. Each element has a capture/shift stage that works on the rising test-clock edge and an update stage that changes on the falling edge. All elements sit on one serial path from `scan_in` to `scan_out`. A test access port controller outside the block provides the capture, shift and update strobes and a mode select.

In normal and sample modes the core reaches the pads untouched, and the scan path can still record pad and core states. In external-test and clamp modes the update stages take over the pads. The core then sees the input update stage rather than the pad. The high-impedance and configuration modes force every output enable inactive. Stage-to-stage shift data leaves on one clock edge and is picked up on the opposite edge, so clock skew along a long chain does not cause hold failures. A falling-edge retiming stage always feeds `scan_out`. Further falling-edge stages can optionally sit between pad groups.

Top module: `bscan_pad_group`

## Requirements
- R1: A synchronous active-low reset clears every capture/shift stage, every update stage and `scan_out` to 0. All three are sampled on the edge each stage uses.
- R2: `mode_sel` encodings are: 0 functional, 1 external test, 2 sample/preload, 3 clamp, 4 high impedance, 5 configuration. Codes 6 and 7 act as functional. In functional mode `pad_out`=`core_out`, `pad_oe`=`core_oe` and `core_in`=`pad_in`.
- R3: On a rising edge with `capture_en` high in a chain-active mode (0, 1, 2, 5, 6, 7), pad p's three stages load `pad_in[p]`, `core_out[p]` and `core_oe[p]`. Capture takes priority over `shift_en`.
- R4: On a rising edge with `shift_en` high and `capture_en` low in a chain-active mode, the stages shift one place. The order is `scan_in`, then pad 0 input, output data and output enable, then pad 1 in the same order, and so on. The last stage reaches `scan_out` at the following falling edge.
- R5: On a falling edge with `update_en` high in a chain-active mode, every update stage copies its capture/shift stage. In all other cases the update stages hold.
- R6: In external test mode, `pad_out` and `pad_oe` follow the output-data and output-enable update stages, and `core_in` follows the input update stage.
- R7: In clamp mode, the pads and `core_in` are driven as in external test. Capture, shift and update strobes have no effect on any stage.
- R8: In high-impedance mode, `pad_oe` is 0, `pad_out` follows `core_out` and `core_in` follows `pad_in`. The strobes have no effect on any stage.
- R9: In configuration mode, `pad_oe` is 0, `pad_out` follows `core_out` and `core_in` follows `pad_in`. Capture, shift and update still operate.
- R10: In sample/preload mode, pad and core signals pass through as in functional mode while capture, shift and update operate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock; capture/shift on rising, update on falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 3 | Operating mode code |
| capture_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| update_en | input | 1 | Update strobe |
| scan_in | input | 1 | Serial scan input |
| scan_out | output | 1 | Serial scan output, changes on falling edge |
| core_out | input | NUM_PADS | Output data from core |
| core_oe | input | NUM_PADS | Output enable from core |
| core_in | output | NUM_PADS | Input data to core |
| pad_in | input | NUM_PADS | Value received at each pad |
| pad_out | output | NUM_PADS | Output data to each pad |
| pad_oe | output | NUM_PADS | Output enable to each pad |

## Verification
The bench builds the block with three pads and retiming stages between every pad group. Nine scan elements make a full shift-through and a complete reload short enough to repeat many times. The inter-group retiming stages are present, so a wrong edge or a misplaced stage at a pad boundary shows up as a one-position slip in the shifted stream. The reference model steps both clock edges for every mode code, including the unused ones, with random strobes.

// File: rtl/bscan_pkg.sv
// Shared mode encoding and helpers for the pad boundary scan group.
// Assumes mode codes are driven by an external test controller.
package bscan_pkg;

    typedef enum logic [2:0] {
        BS_FUNC   = 3'd0,
        BS_EXTEST = 3'd1,
        BS_SAMPLE = 3'd2,
        BS_CLAMP  = 3'd3,
        BS_HIGHZ  = 3'd4,
        BS_CONFIG = 3'd5
    } bs_mode_e;

    localparam int CELLS_PER_PAD = 3;
    localparam int SLOT_IN  = 0;
    localparam int SLOT_OUT = 1;
    localparam int SLOT_OE  = 2;

    typedef struct packed {
        logic in_v;
        logic out_v;
        logic oe_v;
    } pad_upd_t;

    // Scan stages react to strobes in every mode except clamp and high-Z.
    function automatic logic chain_active(input logic [2:0] m);
        return !(m == BS_CLAMP || m == BS_HIGHZ);
    endfunction

    // Update stages own the pad in external test and clamp.
    function automatic logic scan_owns_pad(input logic [2:0] m);
        return (m == BS_EXTEST || m == BS_CLAMP);
    endfunction

    // Output enable forced off in high-Z and configuration.
    function automatic logic oe_forced_off(input logic [2:0] m);
        return (m == BS_HIGHZ || m == BS_CONFIG);
    endfunction

endpackage

// File: rtl/bscan_cell.sv
// One scan element: a capture/shift stage on the rising edge and an
// update stage on the falling edge. Assumes the controller never needs
// shift while capturing; capture wins if both are high.
module bscan_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic capture,
    input  logic shift,
    input  logic upd,
    input  logic cap_d,
    input  logic si,
    output logic q,
    output logic u
);

    // Capture/shift stage, rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (run && capture)
            q <= cap_d;
        else if (run && shift)
            q <= si;
    end

    // Update stage, falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n)
            u <= 1'b0;
        else if (run && upd)
            u <= q;
    end

    // R4
    cell_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && shift && !capture) |=> (q == $past(si)));

    // R3
    cell_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && capture) |=> (q == $past(cap_d)));

    // R5
    upd_hold_chk: assert property (@(negedge clk) disable iff (!rst_n)
        !(run && upd) |=> $stable(u));

    // R5
    upd_load_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (run && upd) |=> (u == $past(q)));

endmodule

// File: rtl/bscan_lockup.sv
// Falling-edge retiming stage placed after a rising-edge launcher so the
// next rising-edge receiver sees data held across half a period.
module bscan_lockup (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    // Retime on the opposite edge.
    always_ff @(negedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else
            q <= d;
    end

endmodule

// File: rtl/bscan_pad_mux.sv
// Per-pad selection between core signals and update stages by mode.
// Purely combinational; assumes the update values are stable per half period.
module bscan_pad_mux
    import bscan_pkg::*;
(
    input  logic [2:0] mode,
    input  logic       core_out,
    input  logic       core_oe,
    input  logic       pad_in,
    input  pad_upd_t   upd,
    output logic       pad_out,
    output logic       pad_oe,
    output logic       core_in
);

    // Steer pad and core sides from mode.
    always_comb begin
        if (scan_owns_pad(mode)) begin
            pad_out = upd.out_v;
            pad_oe  = upd.oe_v;
            core_in = upd.in_v;
        end else begin
            pad_out = core_out;
            pad_oe  = oe_forced_off(mode) ? 1'b0 : core_oe;
            core_in = pad_in;
        end
    end

endmodule

// File: rtl/bscan_pad_group.sv
// Boundary scan cells for NUM_PADS bidirectional pads, three elements
// per pad on one serial path. LOCKUP_EVERY_PAD inserts a falling-edge
// retiming stage between pad groups; one always feeds scan_out.
module bscan_pad_group
    import bscan_pkg::*;
#(
    parameter int NUM_PADS         = 8,
    parameter bit LOCKUP_EVERY_PAD = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          mode_sel,
    input  logic                capture_en,
    input  logic                shift_en,
    input  logic                update_en,
    input  logic                scan_in,
    output logic                scan_out,
    input  logic [NUM_PADS-1:0] core_out,
    input  logic [NUM_PADS-1:0] core_oe,
    output logic [NUM_PADS-1:0] core_in,
    input  logic [NUM_PADS-1:0] pad_in,
    output logic [NUM_PADS-1:0] pad_out,
    output logic [NUM_PADS-1:0] pad_oe
);

    localparam int NUM_CELLS = NUM_PADS * CELLS_PER_PAD;
    localparam int LAST      = NUM_CELLS - 1;

    logic                 run;
    logic [NUM_CELLS-1:0] chain_q;
    logic [NUM_CELLS-1:0] chain_u;
    logic [NUM_CELLS-1:0] chain_si;
    logic [NUM_CELLS-1:0] chain_cap;
    logic [NUM_PADS-1:0]  pad_tail;

    assign run = chain_active(mode_sel);

    generate
        for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
            localparam int B = p * CELLS_PER_PAD;

            assign chain_cap[B + SLOT_IN]  = pad_in[p];
            assign chain_cap[B + SLOT_OUT] = core_out[p];
            assign chain_cap[B + SLOT_OE]  = core_oe[p];

            // Entry of this pad's group.
            if (p == 0) begin : g_head
                assign chain_si[B] = scan_in;
            end else begin : g_link
                assign chain_si[B] = pad_tail[p-1];
            end
            assign chain_si[B + SLOT_OUT] = chain_q[B + SLOT_IN];
            assign chain_si[B + SLOT_OE]  = chain_q[B + SLOT_OUT];

            // Exit of this pad's group, retimed when selected.
            if (LOCKUP_EVERY_PAD && p < NUM_PADS - 1) begin : g_lock
                bscan_lockup u_lock (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .d     (chain_q[B + SLOT_OE]),
                    .q     (pad_tail[p])
                );
            end else begin : g_direct
                assign pad_tail[p] = chain_q[B + SLOT_OE];
            end

            for (genvar s = 0; s < CELLS_PER_PAD; s++) begin : g_slot
                bscan_cell u_cell (
                    .clk     (clk),
                    .rst_n   (rst_n),
                    .run     (run),
                    .capture (capture_en),
                    .shift   (shift_en),
                    .upd     (update_en),
                    .cap_d   (chain_cap[B + s]),
                    .si      (chain_si[B + s]),
                    .q       (chain_q[B + s]),
                    .u       (chain_u[B + s])
                );
            end

            pad_upd_t upd_v;
            assign upd_v = '{in_v:  chain_u[B + SLOT_IN],
                             out_v: chain_u[B + SLOT_OUT],
                             oe_v:  chain_u[B + SLOT_OE]};

            bscan_pad_mux u_mux (
                .mode     (mode_sel),
                .core_out (core_out[p]),
                .core_oe  (core_oe[p]),
                .pad_in   (pad_in[p]),
                .upd      (upd_v),
                .pad_out  (pad_out[p]),
                .pad_oe   (pad_oe[p]),
                .core_in  (core_in[p])
            );
        end
    endgenerate

    bscan_lockup u_tail_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (chain_q[LAST]),
        .q     (scan_out)
    );

    // R8 R9
    oe_forced_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == BS_HIGHZ || mode_sel == BS_CONFIG) |-> (pad_oe == '0));

    // R7
    clamp_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == BS_CLAMP || mode_sel == BS_HIGHZ) |=> $stable(chain_q));

    // R4
    scan_out_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_out == chain_q[LAST]);

endmodule

// File: tb/bscan_pad_group_test.sv
module bscan_pad_group_test;

    localparam int NP = 3;
    localparam int NC = NP * 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    mode_sel = 3'd0;
    logic          capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0;
    logic          scan_in = 1'b0;
    logic          scan_out;
    logic [NP-1:0] core_out = '0, core_oe = '0, pad_in = '0;
    logic [NP-1:0] core_in, pad_out, pad_oe;

    bscan_pad_group #(.NUM_PADS(NP), .LOCKUP_EVERY_PAD(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .capture_en(capture_en), .shift_en(shift_en), .update_en(update_en),
        .scan_in(scan_in), .scan_out(scan_out),
        .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    always #5 clk = ~clk;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string cur_req = "R1";

    bit m_sh[NC];
    bit m_up[NC];
    bit m_so;

    function automatic bit m_active(input int m);
        return !(m == 3 || m == 4);
    endfunction

    task automatic check(input string what, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        bit nx[NC];
        logic [NP-1:0] e_po, e_oe, e_ci;
        @(posedge clk);
        nx = m_sh;
        if (!rst_n) begin
            foreach (nx[k]) nx[k] = 0;
        end else if (m_active(mode_sel)) begin
            if (capture_en) begin
                for (int p = 0; p < NP; p++) begin
                    nx[3*p]   = pad_in[p];
                    nx[3*p+1] = core_out[p];
                    nx[3*p+2] = core_oe[p];
                end
            end else if (shift_en) begin
                nx[0] = scan_in;
                for (int k = 1; k < NC; k++) nx[k] = m_sh[k-1];
            end
        end
        m_sh = nx;
        @(negedge clk);
        if (!rst_n) begin
            foreach (m_up[k]) m_up[k] = 0;
            m_so = 0;
        end else begin
            if (m_active(mode_sel) && update_en) m_up = m_sh;
            m_so = m_sh[NC-1];
        end
        #1;
        for (int p = 0; p < NP; p++) begin
            if (mode_sel == 1 || mode_sel == 3) begin
                e_po[p] = m_up[3*p+1];
                e_oe[p] = m_up[3*p+2];
                e_ci[p] = m_up[3*p];
            end else begin
                e_po[p] = core_out[p];
                e_oe[p] = (mode_sel == 4 || mode_sel == 5) ? 1'b0 : core_oe[p];
                e_ci[p] = pad_in[p];
            end
        end
        check("pad_out", pad_out, e_po);
        check("pad_oe", pad_oe, e_oe);
        check("core_in", core_in, e_ci);
        check("scan_out", {{(NP-1){1'b0}}, scan_out}, {{(NP-1){1'b0}}, m_so});
    endtask

    task automatic rnd_pads();
        core_out = NP'($urandom);
        core_oe  = NP'($urandom);
        pad_in   = NP'($urandom);
    endtask

    task automatic rnd_strobes();
        capture_en = 1'($urandom);
        shift_en   = 1'($urandom);
        update_en  = 1'($urandom);
        scan_in    = 1'($urandom);
    endtask

    initial begin
        // R1: reset state, then observe reset update stages via external test
        cur_req = "R1";
        rnd_pads();
        repeat (3) tick();
        rst_n = 1'b1;
        mode_sel = 3'd1;
        repeat (2) tick();

        // R2: functional pass-through with chain activity
        cur_req = "R2";
        mode_sel = 3'd0;
        for (int i = 0; i < 10; i++) begin rnd_pads(); rnd_strobes(); tick(); end

        // R10: sample/preload keeps pads untouched
        cur_req = "R10";
        mode_sel = 3'd2;
        capture_en = 1; shift_en = 0; update_en = 0;
        rnd_pads(); tick();
        // R3: capture wins over shift
        cur_req = "R3";
        capture_en = 1; shift_en = 1; rnd_pads(); tick();
        capture_en = 0; shift_en = 1;
        // R4: full shift-out of captured values and shift-in of new ones
        cur_req = "R4";
        for (int i = 0; i < NC + 2; i++) begin scan_in = 1'($urandom); rnd_pads(); tick(); end

        // R5: hold without update, then load with update
        cur_req = "R5";
        mode_sel = 3'd1;
        shift_en = 1;
        for (int i = 0; i < NC; i++) begin scan_in = 1'(i % 2); tick(); end
        shift_en = 0; update_en = 0; tick();
        update_en = 1; tick();
        update_en = 0;

        // R6: external test drives pads from update stages
        cur_req = "R6";
        for (int i = 0; i < 6; i++) begin rnd_pads(); tick(); end
        shift_en = 1;
        for (int i = 0; i < NC; i++) begin scan_in = 1'($urandom); rnd_pads(); tick(); end
        shift_en = 0; update_en = 1; tick(); update_en = 0; tick();

        // R7: clamp ignores every strobe
        cur_req = "R7";
        mode_sel = 3'd3;
        for (int i = 0; i < 12; i++) begin rnd_pads(); rnd_strobes(); tick(); end
        capture_en = 0; shift_en = 0; update_en = 0;
        mode_sel = 3'd1; tick();

        // R8: high impedance
        cur_req = "R8";
        mode_sel = 3'd4;
        for (int i = 0; i < 12; i++) begin rnd_pads(); rnd_strobes(); tick(); end

        // R9: configuration keeps chain working with outputs released
        cur_req = "R9";
        mode_sel = 3'd5;
        for (int i = 0; i < 12; i++) begin rnd_pads(); rnd_strobes(); tick(); end
        capture_en = 0; shift_en = 0; update_en = 0;
        mode_sel = 3'd1; tick();

        // R2: mixed modes including unused codes
        cur_req = "R2";
        for (int i = 0; i < 300; i++) begin
            mode_sel = 3'($urandom);
            rnd_pads(); rnd_strobes(); tick();
        end

        // R1: reset again mid-run
        cur_req = "R1";
        rst_n = 1'b0; rnd_strobes(); tick(); tick();
        rst_n = 1'b1; capture_en = 0; shift_en = 0; update_en = 0;
        mode_sel = 3'd1; tick();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule